// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block holds instructions that are ready to execute, grouped by operation class so that each class feeds its own group of functional units. Every cycle it grants up to a fixed number of them, always the oldest available. Age comes from a sequence number: a smaller number means an older instruction. The choice works in two levels. Each class first finds its own oldest entry. The selector then takes the oldest of those class heads. When a class wins a lane, its next-oldest entry becomes its new head and competes for the next lane in the same cycle.

A class whose functional unit reports busy is left out for the whole cycle. Its entries stay stored, and a per-class saturating stall counter records the cycle. A squash input discards every stored entry younger than a given sequence number. It also blocks those entries from being granted in the cycle the squash is asserted. New entries arrive one per cycle with a sequence number and a class.

Grants are combinational from the stored state and the current busy and squash inputs. Granted entries leave storage at the next clock edge.

Top module: `isq_issue_select`

## Requirements
- R1: After reset no entry is stored, every `grantValid` bit is 0 and every stall counter reads 0.
- R2: Within one class, an entry with a smaller sequence number is granted before one with a larger number. Sequence numbers are 16-bit and compared as unsigned values, and wraparound is not handled.
- R3: Across classes, the lanes are filled by repeatedly taking the oldest of the current class heads. After a class wins a lane, its next-oldest entry competes for later lanes in the same cycle, so one class may take several lanes.
- R4: At most `ISSUE_W` grants are made per cycle. Used lanes are packed from lane 0 upward with strictly increasing sequence numbers. `grantClass` carries the class index (0 to 7) of each grant.
- R5: A class whose `fuBusy` bit is 1 receives no grant in that cycle and keeps its entries. Its lanes go to the next-oldest heads of the other classes.
- R6: In each cycle where a class's `fuBusy` bit is 1 and that class holds at least one entry that is not being squashed, its stall counter rises by 1 at the clock edge. The counter saturates at its all-ones value. Counter c sits at `busyCount[c*CNT_W +: CNT_W]`.
- R7: While `squashValid` is 1, entries with a sequence number greater than `squashSeq` are not granted and are removed at the clock edge. Entries with a number at or below `squashSeq` are unaffected.
- R8: An insert is dropped when its class already holds 8 entries in that cycle. It is also dropped when a squash is asserted in the same cycle and the insert's sequence number is greater than `squashSeq`.
- R9: An inserted entry can first be granted in the cycle after `insValid` was sampled high.
- R10: A granted entry is removed at the clock edge and is never granted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| insValid | input | 1 | Insert a ready entry this cycle |
| insSeq | input | 16 | Sequence number of the inserted entry |
| insClass | input | 3 | Operation class of the inserted entry |
| fuBusy | input | 8 | Per-class functional-unit busy flags |
| squashValid | input | 1 | Squash request |
| squashSeq | input | 16 | Entries younger than this number are discarded |
| grantValid | output | ISSUE_W | Per-lane grant valid, lane 0 oldest |
| grantSeq | output | ISSUE_W*16 | Per-lane granted sequence number |
| grantClass | output | ISSUE_W*3 | Per-lane granted class index |
| busyCount | output | 8*CNT_W | Per-class saturating stall counters |

## Verification
The bench builds the block with `ISSUE_W=3`. With three lanes the width limit is reached often among eight classes, and the bench can show one class taking several lanes in a single cycle. It uses `CNT_W=4`, so a stall counter reaches saturation after fifteen busy cycles and the hold at all-ones can be observed. With the default 16-bit counter that would take tens of thousands of cycles. A behavioural model runs alongside the block, and its sorted candidate lists are compared with every lane and every counter each cycle. This covers directed cases for ordering, busy skipping, squash and dropped inserts, followed by a long mixed random phase.

// File: rtl/isq_pkg.sv
package isq_pkg;
  parameter int NUM_CLASSES = 8;
  parameter int CLASS_DEPTH = 8;
  parameter int SEQ_W       = 16;
  parameter int CLS_W       = $clog2(NUM_CLASSES);
  parameter int SLOT_W      = $clog2(CLASS_DEPTH);

  typedef logic [SEQ_W-1:0] seq_t;
  typedef logic [NUM_CLASSES-1:0][CLASS_DEPTH-1:0] entMask_t;
  typedef seq_t [NUM_CLASSES-1:0][CLASS_DEPTH-1:0] entSeq_t;

  // Strobes from the control to the entry storage.
  typedef struct packed {
    entMask_t                clearMask;
    logic                    insWr;
    logic [CLS_W-1:0]        insClass;
    logic [SLOT_W-1:0]       insSlot;
    seq_t                    insSeq;
    logic [NUM_CLASSES-1:0]  busyBump;
  } isqStrobe_t;
endpackage

// File: rtl/isq_age_picker.sv
// One issue lane: oldest entry per class, then oldest among class heads.
module isq_age_picker
  import isq_pkg::*;
(
  input  entMask_t          avail,
  input  entSeq_t           seqs,
  output logic              found,
  output logic [CLS_W-1:0]  pickClass,
  output logic [SLOT_W-1:0] pickSlot,
  output seq_t              pickSeq
);
  logic [NUM_CLASSES-1:0]   headValid;
  logic [SLOT_W-1:0]        headSlot [NUM_CLASSES];
  seq_t                     headSeq  [NUM_CLASSES];

  // Level one: class head
  always_comb begin
    for (int c = 0; c < NUM_CLASSES; c++) begin
      headValid[c] = 1'b0;
      headSlot[c]  = '0;
      headSeq[c]   = '0;
      for (int s = 0; s < CLASS_DEPTH; s++) begin
        if (avail[c][s] && (!headValid[c] || seqs[c][s] < headSeq[c])) begin
          headValid[c] = 1'b1;
          headSlot[c]  = SLOT_W'(s);
          headSeq[c]   = seqs[c][s];
        end
      end
    end
  end

  // Level two: oldest class head
  always_comb begin
    found     = 1'b0;
    pickClass = '0;
    pickSlot  = '0;
    pickSeq   = '0;
    for (int c = 0; c < NUM_CLASSES; c++) begin
      if (headValid[c] && (!found || headSeq[c] < pickSeq)) begin
        found     = 1'b1;
        pickClass = CLS_W'(c);
        pickSlot  = headSlot[c];
        pickSeq   = headSeq[c];
      end
    end
  end
endmodule

// File: rtl/isq_control.sv
module isq_control
  import isq_pkg::*;
#(
  parameter int ISSUE_W = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  entMask_t                          entValid,
  input  entSeq_t                           entSeq,
  input  logic [NUM_CLASSES-1:0]            fuBusy,
  input  logic                              insValid,
  input  seq_t                              insSeq,
  input  logic [CLS_W-1:0]                  insClass,
  input  logic                              squashValid,
  input  seq_t                              squashSeq,
  output logic [ISSUE_W-1:0]                grantValid,
  output seq_t [ISSUE_W-1:0]                grantSeq,
  output logic [ISSUE_W-1:0][CLS_W-1:0]     grantClass,
  output isqStrobe_t                        strobe
);
  entMask_t killMask;
  entMask_t eligMask;
  entMask_t remain  [ISSUE_W+1];
  entMask_t cumGrant[ISSUE_W+1];

  always_comb begin
    for (int c = 0; c < NUM_CLASSES; c++) begin
      for (int s = 0; s < CLASS_DEPTH; s++) begin
        killMask[c][s] = entValid[c][s] && squashValid && (entSeq[c][s] > squashSeq);
        eligMask[c][s] = entValid[c][s] && !killMask[c][s] && !fuBusy[c];
      end
    end
  end

  assign remain[0]   = eligMask;
  assign cumGrant[0] = '0;

  for (genvar k = 0; k < ISSUE_W; k++) begin : g_lane
    logic              laneFound;
    logic [CLS_W-1:0]  laneClass;
    logic [SLOT_W-1:0] laneSlot;
    seq_t              laneSeq;
    entMask_t          laneHit;

    isq_age_picker u_pick (
      .avail     (remain[k]),
      .seqs      (entSeq),
      .found     (laneFound),
      .pickClass (laneClass),
      .pickSlot  (laneSlot),
      .pickSeq   (laneSeq)
    );

    always_comb begin
      laneHit = '0;
      if (laneFound) laneHit[laneClass][laneSlot] = 1'b1;
    end

    assign remain[k+1]   = remain[k] & ~laneHit;
    assign cumGrant[k+1] = cumGrant[k] | laneHit;
    assign grantValid[k] = laneFound;
    assign grantSeq[k]   = laneSeq;
    assign grantClass[k] = laneClass;

    if (k > 0) begin : g_order
      AST_LANE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        grantValid[k] |-> (grantValid[k-1] && grantSeq[k-1] < grantSeq[k])); // R4
    end

    AST_NO_BUSY_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      grantValid[k] |-> !fuBusy[grantClass[k]]); // R5

    AST_SQUASH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (grantValid[k] && squashValid) |-> (grantSeq[k] <= squashSeq)); // R7
  end

  // Insert slot: lowest free slot of the target class
  logic              haveFree;
  logic [SLOT_W-1:0] freeSlot;
  always_comb begin
    haveFree = 1'b0;
    freeSlot = '0;
    for (int s = CLASS_DEPTH-1; s >= 0; s--) begin
      if (!entValid[insClass][s]) begin
        haveFree = 1'b1;
        freeSlot = SLOT_W'(s);
      end
    end
  end

  always_comb begin
    strobe.clearMask = cumGrant[ISSUE_W] | killMask;
    strobe.insWr     = insValid && haveFree && !(squashValid && insSeq > squashSeq);
    strobe.insClass  = insClass;
    strobe.insSlot   = freeSlot;
    strobe.insSeq    = insSeq;
    for (int c = 0; c < NUM_CLASSES; c++)
      strobe.busyBump[c] = fuBusy[c] && |(entValid[c] & ~killMask[c]);
  end

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (insValid && &entValid[insClass]) |-> !strobe.insWr); // R8
endmodule

// File: rtl/isq_datapath.sv
module isq_datapath
  import isq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  isqStrobe_t                         strobe,
  output entMask_t                           entValid,
  output entSeq_t                            entSeq,
  output logic [NUM_CLASSES-1:0][CNT_W-1:0]  busyCnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entValid <= '0;
      entSeq   <= '0;
    end else begin
      for (int c = 0; c < NUM_CLASSES; c++) begin
        for (int s = 0; s < CLASS_DEPTH; s++) begin
          if (strobe.insWr && strobe.insClass == CLS_W'(c) && strobe.insSlot == SLOT_W'(s)) begin
            entValid[c][s] <= 1'b1;
            entSeq[c][s]   <= strobe.insSeq;
          end else if (strobe.clearMask[c][s]) begin
            entValid[c][s] <= 1'b0;
          end
        end
      end
    end
  end

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)                                   busyCnt[c] <= '0;
      else if (strobe.busyBump[c] && ~&busyCnt[c])  busyCnt[c] <= busyCnt[c] + 1'b1;
    end

    AST_CNT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> busyCnt[c] >= $past(busyCnt[c])); // R6
  end

  AST_INS_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.insWr |=> entValid[$past(strobe.insClass)][$past(strobe.insSlot)]); // R9
endmodule

// File: rtl/isq_issue_select.sv
module isq_issue_select
  import isq_pkg::*;
#(
  parameter int ISSUE_W = 4,
  parameter int CNT_W   = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          insValid,
  input  logic [SEQ_W-1:0]              insSeq,
  input  logic [CLS_W-1:0]              insClass,
  input  logic [NUM_CLASSES-1:0]        fuBusy,
  input  logic                          squashValid,
  input  logic [SEQ_W-1:0]              squashSeq,
  output logic [ISSUE_W-1:0]            grantValid,
  output logic [ISSUE_W*SEQ_W-1:0]      grantSeq,
  output logic [ISSUE_W*CLS_W-1:0]      grantClass,
  output logic [NUM_CLASSES*CNT_W-1:0]  busyCount
);
  entMask_t                          entValid;
  entSeq_t                           entSeq;
  isqStrobe_t                        strobe;
  seq_t [ISSUE_W-1:0]                laneSeq;
  logic [ISSUE_W-1:0][CLS_W-1:0]     laneClass;
  logic [NUM_CLASSES-1:0][CNT_W-1:0] busyCnt;

  isq_control #(.ISSUE_W(ISSUE_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .entValid    (entValid),
    .entSeq      (entSeq),
    .fuBusy      (fuBusy),
    .insValid    (insValid),
    .insSeq      (insSeq),
    .insClass    (insClass),
    .squashValid (squashValid),
    .squashSeq   (squashSeq),
    .grantValid  (grantValid),
    .grantSeq    (laneSeq),
    .grantClass  (laneClass),
    .strobe      (strobe)
  );

  isq_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .entValid (entValid),
    .entSeq   (entSeq),
    .busyCnt  (busyCnt)
  );

  assign grantSeq   = laneSeq;
  assign grantClass = laneClass;
  assign busyCount  = busyCnt;
endmodule

// File: tb/tb_isq_issue_select.sv
`timescale 1ns/1ps
module tb_isq_issue_select;
  localparam int IW = 3;
  localparam int CW = 4;
  localparam int NC = 8;
  localparam int DEPTH = 8;
  localparam int CNT_MAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic insValid = 1'b0;
  logic [15:0] insSeq = '0;
  logic [2:0] insClass = '0;
  logic [7:0] fuBusy = '0;
  logic squashValid = 1'b0;
  logic [15:0] squashSeq = '0;
  logic [IW-1:0] grantValid;
  logic [IW*16-1:0] grantSeq;
  logic [IW*3-1:0] grantClass;
  logic [NC*CW-1:0] busyCount;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  int q [NC][$];
  int cnt [NC];

  always #5 clk = ~clk;

  isq_issue_select #(.ISSUE_W(IW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .insValid(insValid), .insSeq(insSeq),
    .insClass(insClass), .fuBusy(fuBusy), .squashValid(squashValid),
    .squashSeq(squashSeq), .grantValid(grantValid), .grantSeq(grantSeq),
    .grantClass(grantClass), .busyCount(busyCount)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkCounters();
    for (int c = 0; c < NC; c++)
      check("R6", $sformatf("stall counter %0d", c), int'(busyCount[c*CW +: CW]), cnt[c]);
  endtask

  // One cycle: drive at negedge, compare grants, advance the model.
  task automatic step(input bit iv, input int is, input int ic,
                      input logic [7:0] busy, input bit sv, input int ss);
    int cand[$];
    int occ;
    int g;
    @(negedge clk);
    checkCounters();
    insValid = iv; insSeq = 16'(is); insClass = 3'(ic);
    fuBusy = busy; squashValid = sv; squashSeq = 16'(ss);
    #1;
    for (int c = 0; c < NC; c++)
      foreach (q[c][i])
        if (!(sv && q[c][i] > ss) && !busy[c]) cand.push_back(q[c][i] * 16 + c);
    cand.sort();
    for (int k = 0; k < IW; k++) begin
      bit ev = (k < cand.size());
      check(tag, $sformatf("lane %0d valid", k), int'(grantValid[k]), int'(ev));
      if (ev) begin
        check(tag, $sformatf("lane %0d seq", k), int'(grantSeq[k*16 +: 16]), cand[k] / 16);
        check(tag, $sformatf("lane %0d class", k), int'(grantClass[k*3 +: 3]), cand[k] % 16);
      end
    end
    occ = q[ic].size();
    for (int c = 0; c < NC; c++) begin
      int live = 0;
      foreach (q[c][i]) if (!(sv && q[c][i] > ss)) live++;
      if (busy[c] && live > 0 && cnt[c] < CNT_MAX) cnt[c]++;
    end
    for (int k = 0; k < IW && k < cand.size(); k++) begin
      int c = cand[k] % 16;
      int s = cand[k] / 16;
      foreach (q[c][i]) if (q[c][i] == s) g = i;
      q[c].delete(g);
    end
    if (sv)
      for (int c = 0; c < NC; c++) begin
        int keep[$];
        foreach (q[c][i]) if (q[c][i] <= ss) keep.push_back(q[c][i]);
        q[c] = keep;
      end
    if (iv && !(sv && is > ss) && occ < DEPTH) q[ic].push_back(is);
  endtask

  task automatic idle(input logic [7:0] busy, input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, busy, 0, 0);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    for (int c = 0; c < NC; c++) cnt[c] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    #1;
    check("R1", "grantValid after reset", int'(grantValid), 0);
    checkCounters();
    idle(8'h00, 2);

    // R2: out-of-order inserts into one class while busy, then release
    tag = "R2";
    step(1, 50, 2, 8'h04, 0, 0);
    step(1, 20, 2, 8'h04, 0, 0);
    step(1, 35, 2, 8'h04, 0, 0);
    idle(8'h00, 2);

    // R3: class heads compete, one class may take several lanes
    tag = "R3";
    step(1, 100, 0, 8'hFF, 0, 0);
    step(1, 90, 1, 8'hFF, 0, 0);
    step(1, 95, 3, 8'hFF, 0, 0);
    step(1, 120, 1, 8'hFF, 0, 0);
    step(1, 92, 0, 8'hFF, 0, 0);
    step(1, 91, 1, 8'hFF, 0, 0);
    idle(8'h00, 3);

    // R4: more ready entries than lanes
    tag = "R4";
    for (int i = 0; i < 8; i++) step(1, 300 - i * 7, i, 8'hFF, 0, 0);
    idle(8'h00, 4);

    // R5: busy class keeps entries while others issue
    tag = "R5";
    step(1, 400, 1, 8'h02, 0, 0);
    step(1, 410, 4, 8'h02, 0, 0);
    step(1, 405, 1, 8'h02, 0, 0);
    idle(8'h02, 3);
    idle(8'h00, 2);

    // R6: saturation of one stall counter
    tag = "R6";
    step(1, 500, 5, 8'h20, 0, 0);
    idle(8'h20, 20);
    idle(8'h00, 2);

    // R7: squash blocks and removes younger entries
    tag = "R7";
    step(1, 610, 6, 8'hFF, 0, 0);
    step(1, 600, 3, 8'hFF, 0, 0);
    step(1, 620, 3, 8'hFF, 0, 0);
    step(0, 0, 0, 8'h00, 1, 605);
    idle(8'h00, 2);

    // R8: full-class drop and squash-time insert drop
    tag = "R8";
    for (int i = 0; i < 9; i++) step(1, 700 + i, 6, 8'h40, 0, 0);
    step(1, 800, 7, 8'hFF, 1, 750);
    step(1, 740, 7, 8'hFF, 1, 750);
    idle(8'h00, 5);

    // R9: insert then immediate observation
    tag = "R9";
    step(1, 900, 0, 8'h00, 0, 0);
    step(1, 901, 4, 8'h00, 0, 0);
    idle(8'h00, 2);

    // R10: long mixed traffic
    tag = "R10";
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      logic [7:0] b;
      for (int c = 0; c < NC; c++) b[c] = ($urandom_range(0, 3) == 0);
      step(r < 70, ((n + 1000) * 37) % 65536, $urandom_range(0, 7), b,
           $urandom_range(0, 19) == 0, $urandom_range(0, 65535));
    end
    idle(8'h00, 4);
    @(negedge clk);
    checkCounters();
    finishRun();
  end
endmodule